// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fifteen maskable interrupt sources for a small 8-bit processor. Seven of the sources are external pins, such as edge interrupts and counter inputs. The other eight are single-cycle completion strobes from timers, two serial units and a converter. Each source has a pending flag and an enable flag. Software reaches both through a byte-wide register port. A fifth register selects the active edge of each external pin.

The block holds the global disable flag. The processor sets and clears it with two pulse inputs. A break input requests an interrupt that no flag can mask.

Whenever something can be taken, the block picks the winner by fixed priority. One clock later it raises a one-cycle acknowledge and presents the winner's 16-bit vector address. In the same edge it clears the winner's pending flag and sets the global disable flag. The processor uses the acknowledge to fetch the vector. Stacking of processor state is not part of this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A maskable source is taken only when its pending bit is 1, its enable bit is 1 and the global disable flag is 0. While the flag is 1, no maskable source produces an acknowledge.
- R2: Register writes act on pending bits as follows.
  - A written 0 clears the pending bit; a written 1 leaves it unchanged. Software can never set a pending bit.
  - A hardware event in the same cycle as a clearing write wins, and the bit ends up set.
  - Enable registers hold what was written and read it back.
- R3: Among eligible sources, the lowest source index wins. Sources are numbered as follows:
  - 0 edge pin A, 1 edge pin B, 2 serial-1 receive, 3 serial-1 transmit, 4 timer X, 5 timer Y, 6 timer 1, 7 timer 2.
  - 8 counter pin 0, 9 counter pin 1, 10 serial-2, 11 edge pin C, 12 edge pin D, 13 edge pin E, 14 converter.
  - Register address 0 holds sources 0..7 in bits 0..7. Address 1 holds sources 8..14 in bits 0..6. Enables use the same layout at addresses 2 and 3.
- R4: The vector address follows from the winner.
  - A taken source with index s gives vector 0xFFFA - 2*s. The break gives 0xFFDC.
  - The vector output changes only in the cycle that acknowledge is high.
- R5: Acceptance takes effect in the cycle after the winner is chosen. In that cycle:
  - acknowledge is high for exactly that one cycle;
  - the winner's pending bit is clear unless a new event set it;
  - the disable flag is 1.
  Outside acceptance, disable-set wins over disable-clear.
- R6: A break pulse is remembered until it is taken. It is taken even when the disable flag is 1, but only when no maskable source is eligible.
- R7: External pins pass through a two-flop synchronizer. Edge-select bit 0 detects falling edges and 1 detects rising edges. A pin change applied before clock edge k shows as a pending bit after edge k+3.
  - External pin inputs 0..6 map to sources 0,1,8,9,11,12,13.
  - Event strobes 0..7 map to sources 2,3,4,5,6,7,10,14.
  - Edge selects live at address 4, bits 0..6, in pin-input order.
- R8: Changing an edge-select bit sets the matching pending bit, with the same latency as a real edge, when the pin's current level matches the level that follows an edge of the new polarity.
- R9: Bit 7 of addresses 1, 3 and 4 reads 0. Addresses 5 to 7 read 0.
- R10: After reset:
  - all pending, enable and edge-select bits are 0;
  - the disable flag is 1;
  - acknowledge is 0;
  - the vector reads 0xFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 7 | External interrupt pins, asynchronous |
| evt_i | input | 8 | Internal completion strobes, one cycle each |
| brk_i | input | 1 | Software break request pulse |
| dis_set_i | input | 1 | Set the global disable flag |
| dis_clr_i | input | 1 | Clear the global disable flag |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i, combinational |
| ack_o | output | 1 | One-cycle acceptance strobe |
| vec_o | output | 16 | Vector address of the last accepted interrupt |
| dis_o | output | 1 | Global disable flag |

## Verification
The assertions assume the following about the inputs:
- every input except the external pins is synchronous to the clock;
- the address is stable while the read data is sampled;
- the break and event inputs are single-cycle pulses of a valid width.

The pins themselves may change at any time.

The bench drives all inputs one time unit after the rising edge and samples half a period later. Its random phase changes pins at random while keeping every other input a clean one-cycle pulse. Polarity flips are included so that spurious edge sets and real edges overlap with register clears and acceptances.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter logic [15:0] VEC_BASE = 16'hFFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  pin_i,
  input  logic [7:0]  evt_i,
  input  logic        brk_i,
  input  logic        dis_set_i,
  input  logic        dis_clr_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        ack_o,
  output logic [15:0] vec_o,
  output logic        dis_o
);
  localparam int NSRC = 15;
  localparam int NPIN = 7;
  localparam logic [15:0] VEC_BRK = VEC_BASE - 16'd32;

  logic [NSRC-1:0] req_q, en_q, set_v, elig, win_oh, keep_v;
  logic [NPIN-1:0] sel_q, s1_q, s2_q, eff, eff_q, det_q;
  logic            brk_q, any_m, take, brk_win;
  logic [3:0]      win_idx;
  logic [15:0]     cand_vec;

  assign eff   = ~(s2_q ^ sel_q);
  assign set_v = {evt_i[7], det_q[6:4], evt_i[6], det_q[3:2], evt_i[5:0], det_q[1:0]};
  assign elig  = dis_o ? '0 : (req_q & en_q);
  assign any_m = |elig;
  assign take  = any_m | brk_q;
  assign brk_win = brk_q & ~any_m;

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win_idx = 4'(i);
  end

  assign win_oh   = any_m ? (15'd1 << win_idx) : '0;
  assign cand_vec = any_m ? VEC_BASE - {11'd0, win_idx + 4'd1, 1'b0} : VEC_BRK;

  always_comb begin
    keep_v = '1;
    if (wr_i && addr_i == 3'd0) keep_v[7:0]  = wdata_i;
    if (wr_i && addr_i == 3'd1) keep_v[14:8] = wdata_i[6:0];
  end

  always_comb begin
    case (addr_i)
      3'd0:    rdata_o = req_q[7:0];
      3'd1:    rdata_o = {1'b0, req_q[14:8]};
      3'd2:    rdata_o = en_q[7:0];
      3'd3:    rdata_o = {1'b0, en_q[14:8]};
      3'd4:    rdata_o = {1'b0, sel_q};
      default: rdata_o = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= '0;
      sel_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      eff_q <= '1;
      det_q <= '0;
      brk_q <= 1'b0;
      dis_o <= 1'b1;
      ack_o <= 1'b0;
      vec_o <= VEC_BASE;
    end else begin
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      eff_q <= eff;
      det_q <= eff & ~eff_q;
      req_q <= (req_q & keep_v & ~win_oh) | set_v;
      if (wr_i) begin
        case (addr_i)
          3'd2:    en_q[7:0]  <= wdata_i;
          3'd3:    en_q[14:8] <= wdata_i[6:0];
          3'd4:    sel_q      <= wdata_i[6:0];
          default: ;
        endcase
      end
      brk_q <= brk_i | (brk_q & ~brk_win);
      dis_o <= take | dis_set_i | (dis_o & ~dis_clr_i);
      ack_o <= take;
      if (take) vec_o <= cand_vec;
    end
  end

  assert_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && vec_o != VEC_BRK) |-> $past(!dis_o));

  assert_no_sw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q & ~$past(req_q) & ~$past(set_v)) == '0);

  assert_vec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> $stable(vec_o));

  assert_vec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (!vec_o[0] && vec_o <= VEC_BASE - 16'd2 && vec_o >= VEC_BRK));

  assert_dis_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> dis_o);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 3'd1 || addr_i == 3'd3 || addr_i == 3'd4) |-> !rdata_o[7]);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [6:0] pin = 0;
  logic [7:0] evt = 0, wd = 0, rdata;
  logic brk = 0, dset = 0, dclr = 0, wr = 0, ack, dis;
  logic [2:0] addr = 0;
  logic [15:0] vec;

  always #2 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .evt_i(evt), .brk_i(brk),
    .dis_set_i(dset), .dis_clr_i(dclr), .wr_i(wr), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .ack_o(ack), .vec_o(vec), .dis_o(dis));

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;
  string ph = "R10 reset";

  int ext_src[7] = '{0, 1, 8, 9, 11, 12, 13};
  int evt_src[8] = '{2, 3, 4, 5, 6, 7, 10, 14};
  bit m_req[15], m_en[15], m_sel[7], m_s1[7], m_s2[7], m_effq[7], m_det[7];
  bit m_dis, m_brk, m_ack;
  int m_vec;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, ph, act, exp);
    end
  endtask

  function automatic int m_rd(int a);
    int r = 0;
    case (a)
      0: for (int b = 0; b < 8; b++) r |= int'(m_req[b]) << b;
      1: for (int b = 0; b < 7; b++) r |= int'(m_req[8+b]) << b;
      2: for (int b = 0; b < 8; b++) r |= int'(m_en[b]) << b;
      3: for (int b = 0; b < 7; b++) r |= int'(m_en[8+b]) << b;
      4: for (int b = 0; b < 7; b++) r |= int'(m_sel[b]) << b;
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 15; s++) begin m_req[s] = 0; m_en[s] = 0; end
      for (int k = 0; k < 7; k++) begin
        m_sel[k] = 0; m_s1[k] = 0; m_s2[k] = 0; m_effq[k] = 1; m_det[k] = 0;
      end
      m_dis = 1; m_brk = 0; m_ack = 0; m_vec = 'hFFFC;
    end else begin
      int win;
      bit tk, e;
      bit nreq[15];
      win = -1;
      for (int s = 0; s < 15; s++)
        if (!m_dis && m_req[s] && m_en[s] && win < 0) win = s;
      tk = (win >= 0) || m_brk;
      for (int s = 0; s < 15; s++) nreq[s] = m_req[s];
      if (wr && addr == 0) for (int b = 0; b < 8; b++) if (!wd[b]) nreq[b] = 0;
      if (wr && addr == 1) for (int b = 0; b < 7; b++) if (!wd[b]) nreq[8+b] = 0;
      if (win >= 0) nreq[win] = 0;
      for (int k = 0; k < 7; k++) if (m_det[k]) nreq[ext_src[k]] = 1;
      for (int k = 0; k < 8; k++) if (evt[k]) nreq[evt_src[k]] = 1;
      for (int k = 0; k < 7; k++) begin
        e = m_sel[k] ? m_s2[k] : !m_s2[k];
        m_det[k] = e && !m_effq[k];
        m_effq[k] = e;
        m_s2[k] = m_s1[k];
        m_s1[k] = pin[k];
      end
      if (tk) m_dis = 1;
      else if (dset) m_dis = 1;
      else if (dclr) m_dis = 0;
      if (brk) m_brk = 1;
      else if (tk && win < 0) m_brk = 0;
      m_ack = tk;
      if (tk) m_vec = (win >= 0) ? 'hFFFA - 2 * win : 'hFFDC;
      for (int s = 0; s < 15; s++) m_req[s] = nreq[s];
      if (wr && addr == 2) for (int b = 0; b < 8; b++) m_en[b] = wd[b];
      if (wr && addr == 3) for (int b = 0; b < 7; b++) m_en[8+b] = wd[b];
      if (wr && addr == 4) for (int b = 0; b < 7; b++) m_sel[b] = wd[b];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 ack", int'(ack), int'(m_ack));
      chk("R4 vector", int'(vec), m_vec);
      chk("R5 disable", int'(dis), int'(m_dis));
      chk("R2 readback", int'(rdata), m_rd(int'(addr)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nerr++;
      $display("FAIL R1 watchdog expired actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic nxt();
    @(posedge clk); #1;
    wr = 0; brk = 0; dset = 0; dclr = 0; evt = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) nxt();
  endtask

  task automatic w(logic [2:0] a, logic [7:0] d);
    nxt(); wr = 1; addr = a; wd = d;
    nxt();
  endtask

  task automatic rd(logic [2:0] a);
    nxt(); addr = a;
    nxt();
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ack", int'(ack), 0);
    chk("R10 vector", int'(vec), 'hFFFC);
    chk("R10 disable", int'(dis), 1);
    for (int a = 0; a < 5; a++) rd(3'(a));

    ph = "R2 software clear";
    nxt(); evt = 8'hFF;
    rd(0); rd(1);
    w(0, 8'hFB); w(0, 8'hFF); w(1, 8'h00); rd(0);
    w(0, 8'h00); w(0, 8'hFF); w(1, 8'h7F);
    nxt(); evt = 8'h01; wr = 1; addr = 0; wd = 8'h00;
    rd(0);
    w(2, 8'hA5); w(3, 8'h5A); rd(2); rd(3);

    ph = "R9 unused bits";
    w(3, 8'hFF); w(4, 8'hFF);
    for (int a = 1; a < 8; a++) rd(3'(a));
    w(4, 8'h00); idle(4);

    ph = "R1 masking";
    w(0, 0); w(1, 0); w(2, 0); w(3, 0);
    nxt(); evt = 8'hFF;
    idle(5);
    w(2, 8'h30); idle(4);
    nxt(); dclr = 1; idle(4);
    nxt(); dclr = 1; idle(4);
    nxt(); dclr = 1; idle(4);

    ph = "R3 priority";
    w(2, 8'hFF); w(3, 8'h7F);
    for (int i = 0; i < 12; i++) begin nxt(); dclr = 1; idle(3); end

    ph = "R6 break";
    nxt(); dset = 1; idle(2);
    nxt(); brk = 1; idle(4);
    nxt(); evt = 8'h10; idle(2);
    nxt(); dclr = 1; brk = 1; idle(5);

    ph = "R7 edges";
    w(0, 0); w(1, 0);
    nxt(); dclr = 1;
    nxt(); pin[0] = 1; idle(6);
    nxt(); pin[0] = 0; idle(6);
    nxt(); dclr = 1;
    w(4, 8'h02);
    nxt(); dclr = 1; pin[1] = 1; idle(6);
    nxt(); pin[1] = 0; idle(6);

    ph = "R8 select change";
    nxt(); dset = 1;
    nxt(); pin[2] = 1; idle(6);
    rd(1);
    w(4, 8'h06); idle(5); rd(1);
    nxt(); pin[3] = 0;
    w(4, 8'h0E); w(4, 8'h06); idle(5); rd(1);

    ph = "R5 random";
    for (int i = 0; i < 4000; i++) begin
      nxt();
      for (int k = 0; k < 7; k++) if ($urandom % 8 == 0) pin[k] = ~pin[k];
      if ($urandom % 4 == 0) evt = 8'($urandom) & 8'($urandom);
      if ($urandom % 5 == 0) dclr = 1;
      if ($urandom % 23 == 0) dset = 1;
      if ($urandom % 37 == 0) brk = 1;
      if ($urandom % 9 == 0) begin wr = 1; wd = 8'($urandom); end
      addr = 3'($urandom);
    end
    idle(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule